// File: doc/BRIEF.md
# Harmonic Correction Synthesizer with Soft-Start Gain

This block turns a set of harmonic amplitudes into a duty-cycle correction for a boost power-factor stage. Each amplitude belongs to one odd overtone of the line frequency: the third, the fifth, the seventh and so on. The block multiplies every amplitude by a fixed-point sine of its own order and adds the products. The sum is then scaled by a loop gain that starts at zero and creeps up to its programmed value. The result is negated, because the PWM stage subtracts the correction from its nominal duty.

The rebuilt waveform has eight coarse points per half line period. One switching tick comes from the PWM stage each switching cycle. The block holds every coarse point for a programmable number of these ticks, so one correction word with a strobe comes out per switching cycle. A new amplitude set may be written at any time, but it is taken into use only at the end of a half period. The gain also moves only at that point, so a half period is always built from one consistent set.

Top module: `harmcorr_synth`

## Requirements
- R1: While `en` is low, `corr_stb` and `corr_out` are 0 from the next clock, the point and hold counters return to 0, and the gain is cleared. After `en` rises again, the whole first half period outputs 0.
- R2: While `en` is high, each cycle with `sw_tick` high produces exactly one `corr_stb` pulse in the following clock cycle. `corr_stb` never rises without such a tick.
- R3: For coarse point k (0..7), let m = h*(2k+1), where harmonic i has order h = 2i+3, and let S(m) = round(127*sin(m*pi/16)). The output is -((sum_i a_i*S(m)) * G >>> 15). Here a_i is the active signed amplitude and G is the current unsigned gain. A positive harmonic sum therefore gives a negative correction.
- R4: Each coarse point is presented for `HOLD` consecutive ticks. The points run in the order 0,1,...,7 and then wrap, so a half period is 8*`HOLD` ticks. The first tick after enable presents point 0.
- R5: The gain is 0 when the block is enabled. At the last tick of each half period, it rises by one LSB if it is below `gain_tgt`. It changes at no other time.
- R6: If `gain_tgt` is not above the present gain at a half-period end, the gain takes the value `gain_tgt` there.
- R7: A write with `coef_we` stores `coef_in` as pending; harmonic i sits at bits [i*CW +: CW]. Pending amplitudes become active only at the last tick of a half period, or on any clock while `en` is low.
- R8: The negated result is clamped to the range -2^(OW-1) .. 2^(OW-1)-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low clears gain and counters |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| coef_we | input | 1 | Write strobe for the pending amplitude set |
| coef_in | input | NH*CW | Signed amplitudes, harmonic i at [i*CW +: CW] |
| gain_tgt | input | GW | Unsigned soft-start target gain (G/256) |
| corr_out | output | OW | Signed duty correction to subtract |
| corr_stb | output | 1 | Valid strobe, one per switching tick |

## Verification
A stuck or skipped point or hold counter puts the wrong sine phase on the very next strobe. A wrong gain step shows within one half period as an output scaled by a different amount. An amplitude set made active early changes values before the half-period boundary, so the comparison flags it on the tick after the write. Saturation and negation faults show at once as a sign or magnitude mismatch on each strobe whose sum is large.

// File: rtl/harmcorr_pkg.sv
package harmcorr_pkg;

    localparam int N_PTS    = 8;
    localparam int PT_W     = 3;
    localparam int SIN_W    = 8;
    localparam int SIN_FRAC = 7;

    typedef logic [PT_W-1:0] pt_t;

    typedef struct packed {
        pt_t  pt;
        logic bound;
    } phase_t;

    // Fixed-point sine of m*pi/16, scaled by 127, from a quarter-wave table
    function automatic int sin32(input int m);
        int q;
        int r;
        int v;
        q = m % 16;
        r = (q > 8) ? 16 - q : q;
        case (r)
            0:       v = 0;
            1:       v = 25;
            2:       v = 49;
            3:       v = 71;
            4:       v = 90;
            5:       v = 106;
            6:       v = 117;
            7:       v = 125;
            default: v = 127;
        endcase
        if ((m % 32) >= 16) v = -v;
        return v;
    endfunction

endpackage

// File: rtl/harmcorr_timebase.sv
module harmcorr_timebase
    import harmcorr_pkg::*;
#(
    parameter int HOLD = 104
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    output phase_t ph
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_q;
    pt_t           pt_q;
    logic          last_hold;

    assign last_hold = (hold_q == HW'(HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hold_q <= '0;
            pt_q   <= '0;
        end else if (tick) begin
            if (last_hold) begin
                hold_q <= '0;
                pt_q   <= pt_q + 1'b1;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    assign ph.pt    = pt_q;
    assign ph.bound = en && tick && last_hold && (pt_q == PT_W'(N_PTS - 1));

    AST_PT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (en && tick && last_hold) |=> (pt_q == PT_W'($past(pt_q) + 1'b1))); // R4
    AST_PT_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && !(tick && last_hold)) |=> $stable(pt_q)); // R4

endmodule

// File: rtl/harmcorr_softstart.sv
module harmcorr_softstart #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          bound,
    input  logic [GW-1:0] target,
    output logic [GW-1:0] gain
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gain <= '0;
        end else if (bound) begin
            if (gain < target) gain <= gain + 1'b1;
            else               gain <= target;
        end
    end

    AST_GAIN_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gain == '0)); // R1
    AST_GAIN_STEADY: assert property (@(posedge clk) disable iff (rst)
        (en && !bound) |=> $stable(gain)); // R5
    AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (en && bound) |=> (gain <= $past(target))); // R6

endmodule

// File: rtl/harmcorr_wave.sv
module harmcorr_wave
    import harmcorr_pkg::*;
#(
    parameter int NH = 3,
    parameter int CW = 12,
    parameter int GW = 8,
    parameter int OW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  phase_t               ph,
    input  logic                 coef_we,
    input  logic [NH*CW-1:0]     coef_in,
    input  logic [GW-1:0]        gain,
    output logic signed [OW-1:0] value
);
    localparam int AW = CW + SIN_W + $clog2(NH) + 1;
    localparam int PW = AW + GW + 1;
    localparam int SH = SIN_FRAC + GW;
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - 1;

    logic [NH-1:0][CW-1:0] pend_q;
    logic [NH-1:0][CW-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (coef_we)          pend_q <= coef_in;
            if (!en || ph.bound)  act_q  <= pend_q;
        end
    end

    logic signed [SIN_W-1:0] sin_v [NH];
    logic signed [AW-1:0]    prod  [NH];

    for (genvar i = 0; i < NH; i++) begin : g_harm
        assign sin_v[i] = SIN_W'(sin32((2 * i + 3) * (2 * int'(ph.pt) + 1)));
        assign prod[i]  = AW'(signed'(act_q[i])) * AW'(sin_v[i]);
    end

    logic signed [AW-1:0] acc;
    logic signed [PW-1:0] full;
    logic signed [PW-1:0] neg;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NH; i++) acc = acc + prod[i];
        full = PW'(acc) * PW'(signed'({1'b0, gain}));
        neg  = -(full >>> SH);
        if (neg > MAXV)      value = OW'(MAXV);
        else if (neg < MINV) value = OW'(MINV);
        else                 value = OW'(neg);
    end

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (en && !ph.bound) |=> $stable(act_q)); // R7

endmodule

// File: rtl/harmcorr_synth.sv
module harmcorr_synth
    import harmcorr_pkg::*;
#(
    parameter int NH   = 3,
    parameter int CW   = 12,
    parameter int GW   = 8,
    parameter int OW   = 12,
    parameter int HOLD = 104
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 sw_tick,
    input  logic                 coef_we,
    input  logic [NH*CW-1:0]     coef_in,
    input  logic [GW-1:0]        gain_tgt,
    output logic signed [OW-1:0] corr_out,
    output logic                 corr_stb
);
    phase_t                ph;
    logic [GW-1:0]         gain;
    logic signed [OW-1:0]  value;

    harmcorr_timebase #(.HOLD(HOLD)) tb_i (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (sw_tick),
        .ph   (ph)
    );

    harmcorr_softstart #(.GW(GW)) ss_i (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .bound  (ph.bound),
        .target (gain_tgt),
        .gain   (gain)
    );

    harmcorr_wave #(.NH(NH), .CW(CW), .GW(GW), .OW(OW)) wv_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ph      (ph),
        .coef_we (coef_we),
        .coef_in (coef_in),
        .gain    (gain),
        .value   (value)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            corr_out <= '0;
            corr_stb <= 1'b0;
        end else begin
            corr_stb <= sw_tick;
            if (sw_tick) corr_out <= value;
        end
    end

    AST_STB_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        corr_stb |-> $past(sw_tick && en)); // R2
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (corr_out == '0 && !corr_stb)); // R1

endmodule

// File: tb/harmcorr_synth_tb_top.sv
module harmcorr_synth_tb_top;
    localparam int NH   = 3;
    localparam int CW   = 12;
    localparam int GW   = 8;
    localparam int OW   = 12;
    localparam int HOLD = 3;
    localparam int HALF = 8 * HOLD;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 en = 1'b0;
    logic                 sw_tick = 1'b0;
    logic                 coef_we = 1'b0;
    logic [NH*CW-1:0]     coef_in = '0;
    logic [GW-1:0]        gain_tgt = '0;
    logic signed [OW-1:0] corr_out;
    logic                 corr_stb;

    always #5 clk = ~clk;

    harmcorr_synth #(.NH(NH), .CW(CW), .GW(GW), .OW(OW), .HOLD(HOLD)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sw_tick  (sw_tick),
        .coef_we  (coef_we),
        .coef_in  (coef_in),
        .gain_tgt (gain_tgt),
        .corr_out (corr_out),
        .corr_stb (corr_stb)
    );

    int n_chk  = 0;
    int n_fail = 0;

    int    exp_q[$];
    string tag_q[$];
    string cur_tag = "R4";

    int m_pt = 0, m_hold = 0, m_gain = 0, m_tgt = 0;
    int m_act [NH];
    int m_pend[NH];
    bit m_en = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int sine_ref(input int m);
        real x;
        x = 127.0 * $sin(3.14159265358979 * m / 16.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic int expect_val(input int pt, input int gain);
        longint acc = 0;
        longint p;
        for (int i = 0; i < NH; i++)
            acc += longint'(m_act[i]) * sine_ref((2 * i + 3) * (2 * pt + 1));
        p = -((acc * gain) >>> 15);
        if (p > 2047)  p = 2047;
        if (p < -2048) p = -2048;
        return int'(p);
    endfunction

    // Driver: one switching tick, pushes expected result when enabled
    task automatic tick(input int gap);
        sw_tick = 1'b1;
        if (m_en) begin
            exp_q.push_back(expect_val(m_pt, m_gain));
            tag_q.push_back(cur_tag);
            if (m_hold == HOLD - 1) begin
                m_hold = 0;
                if (m_pt == 7) begin
                    m_pt = 0;
                    if (m_gain < m_tgt) m_gain++;
                    else                m_gain = m_tgt;
                    for (int i = 0; i < NH; i++) m_act[i] = m_pend[i];
                end else begin
                    m_pt++;
                end
            end else begin
                m_hold++;
            end
        end
        @(negedge clk);
        sw_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic ticks(input int n, input int gap);
        for (int k = 0; k < n; k++) tick(gap);
    endtask

    task automatic write_coef(input int c0, input int c1, input int c2);
        m_pend[0] = c0; m_pend[1] = c1; m_pend[2] = c2;
        for (int i = 0; i < NH; i++) coef_in[i*CW +: CW] = CW'(m_pend[i]);
        coef_we = 1'b1;
        @(negedge clk);
        coef_we = 1'b0;
        if (!m_en) for (int i = 0; i < NH; i++) m_act[i] = m_pend[i];
        @(negedge clk);
    endtask

    task automatic set_en(input bit v);
        en = v;
        m_en = v;
        m_pt = 0; m_hold = 0; m_gain = 0;
        if (!v) for (int i = 0; i < NH; i++) m_act[i] = m_pend[i];
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_tgt(input int t);
        gain_tgt = GW'(t);
        m_tgt = t;
        @(negedge clk);
    endtask

    // Monitor: pops and compares each strobed result
    always @(negedge clk) begin
        if (!rst && corr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected strobe", int'(corr_out), 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(corr_out) == e, t, int'(corr_out), e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_test();
    end

    initial begin
        for (int i = 0; i < NH; i++) begin m_act[i] = 0; m_pend[i] = 0; end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(corr_out == '0, "R1 reset corr_out", int'(corr_out), 0);
        chk(corr_stb == 1'b0, "R1 reset corr_stb", int'(corr_stb), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5 ramp from zero with dense ticks, R3/R4 waveform
        write_coef(600, -300, 150);
        set_tgt(255);
        set_en(1'b1);
        cur_tag = "R5";
        ticks(4 * HALF, 0);

        // R2 sparse ticks
        cur_tag = "R2";
        ticks(2 * HALF, 2);

        // R7 mid-period write takes effect only at boundary
        cur_tag = "R7";
        ticks(5, 0);
        write_coef(1000, 0, -500);
        ticks(2 * HALF - 5, 1);

        // R3 long ramp up to full gain, R4 ordering throughout
        cur_tag = "R3";
        ticks(260 * HALF, 0);

        // R8 saturation with large amplitudes
        write_coef(2047, 2047, 2047);
        cur_tag = "R8";
        ticks(2 * HALF, 0);
        write_coef(-2047, 1200, -900);
        ticks(2 * HALF, 0);

        // R6 target lowered below the present gain
        set_tgt(10);
        cur_tag = "R6";
        ticks(3 * HALF, 0);

        // R1 disable: no strobes, zero output, gain cleared
        set_en(1'b0);
        ticks(6, 0);
        chk(corr_stb == 1'b0, "R1 disabled corr_stb", int'(corr_stb), 0);
        chk(corr_out == '0, "R1 disabled corr_out", int'(corr_out), 0);
        write_coef(1500, -700, 400);
        set_tgt(200);
        set_en(1'b1);
        cur_tag = "R1";
        ticks(HALF, 0);
        cur_tag = "R5";
        ticks(2 * HALF, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 missing strobes", exp_q.size(), 0);
        finish_test();
    end

endmodule